// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a management-bus master that runs one register read or one register write to a PHY each time the host asks for it. The host gives a direction bit, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block builds the serial frame, drives the management clock and the data line, and handles the bus turnaround. It releases the line at the end of the frame and returns the read value or an error.

The management clock is made from the system clock by a programmable half-period divider. The divider value is captured when a request is accepted. Time on the bus is counted in bit slots. Each slot is a low phase followed by a high phase, and each phase lasts the programmed number of system cycles. The data line only changes when the management clock falls. Read bits and the turnaround bit are sampled in the last system cycle of a high phase.

A read whose turnaround bit is not pulled low by the PHY does not return data. The block instead clocks 32 extra slots with the line released, so a PHY that has lost sync can recover. It then reports the error.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 slots in which the data line is enabled and driven high.
- R2: The next 14 driven slots (slots 32 to 45) carry, in order: the start pair 0,1; the opcode, which is 1,0 for a read and 0,1 for a write; the PHY address MSB first; then the register address MSB first.
- R3: Every management-clock low phase and high phase lasts exactly `half_div` system cycles. The data output and its enable stay unchanged while the management clock is high.
- R4: A write drives 1,0 in slots 46 and 47, then the 16 data bits MSB first in slots 48 to 63. It then releases the line for one final slot, 65 slots in total.
- R5: A read releases the line from slot 46 onward. It samples the turnaround bit at the end of the high phase of slot 46. It samples the data MSB first at the end of the high phase of slots 47 to 62, and then adds two released slots, 65 slots in total. `rdata` carries the sampled word in the cycle of `done`.
- R6: If the sampled turnaround bit is 1, the read ends after 32 further released slots, 79 slots in total. `err` is 1 and `rdata` is 0 in the cycle of `done`.
- R7: `start` is acted on only when `busy` is low; a `start` during a frame has no effect. `busy` is high from the cycle after acceptance until the cycle before `done`. `done` is a one-cycle pulse. `err` is set only together with `done`, holds its value, and is cleared when the next request is accepted.
- R8: When no frame is in progress, `mdc` is high and `mdio_oe` is low. `half_div` must be at least 1 whenever a request is accepted.
- R9: Reset, even in the middle of a frame, returns the block to idle with `mdc` high, the line released, `busy`, `done` and `err` low and `rdata` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame (taken only when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Value to write |
| half_div | input | DIV_W (8) | System cycles per management-clock phase, at least 1 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Turnaround failure on the last read |
| rdata | output | 16 | Last read value |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input |

## Verification
Some properties are checked on every cycle. The output and its enable must hold steady through each high phase of the management clock. The phase counter must stay below the captured divider. `mdc` must be high with the line released whenever the block is idle. `done` must be a lone pulse in which `busy` is low, and `err` may only rise together with `done`. The bench scenarios cover what needs a whole frame to show: the slot-by-slot content of the preamble, the header, the write turnaround and the data. They also cover the slot counts of 65 and 79, the read word captured from a modelled PHY, the flush after a missing PHY, a request ignored while a frame is in progress, and a reset in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FLUSH_LEN = 32;
    localparam int HDR_BITS  = 4 + 2 * ADDR_W;
    localparam int FRAME_W   = HDR_BITS + 2 + DATA_W;
    localparam int CNT_W     = $clog2(PRE_LEN) + 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_TX,
        PH_TA,
        PH_RX,
        PH_TAIL,
        PH_FLUSH
    } phase_e;

    typedef logic [FRAME_W-1:0] txword_t;

    // Serial word sent after the preamble, first bit in the MSB.
    function automatic txword_t build_frame(input logic is_wr,
                                            input logic [ADDR_W-1:0] pa,
                                            input logic [ADDR_W-1:0] ra,
                                            input logic [DATA_W-1:0] d);
        txword_t w;
        if (is_wr)
            w = {2'b01, 2'b01, pa, ra, 2'b10, d};
        else
            w = {2'b01, 2'b10, pa, ra, {(2 + DATA_W){1'b0}}};
        return w;
    endfunction
endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             phase_end
);
    logic [DIV_W-1:0] cnt;

    assign phase_end = run && (cnt == half_div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (phase_end)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    // R3: a phase never outlasts the captured divider
    a_r3_phase_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < half_div));
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            word <= '0;
        else if (shift)
            word <= {word[W-2:0], bit_in};
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              mdio_in,
    input  logic              phase_end,
    input  logic [DATA_W-1:0] rx_word,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              run,
    output logic [DIV_W-1:0]  div_q,
    output logic              rx_clr,
    output logic              rx_shift
);
    phase_e           ph;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tx_last;
    txword_t          txsr;
    logic             wr_q;
    logic             tail_last;
    logic             accept;
    logic             slot_end;

    assign accept   = start && (ph == PH_IDLE);
    assign slot_end = phase_end && mdc;
    assign busy     = (ph != PH_IDLE);
    assign run      = busy;
    assign rx_clr   = accept;
    assign rx_shift = slot_end && (ph == PH_RX);
    assign tx_last  = wr_q ? CNT_W'(FRAME_W - 1) : CNT_W'(HDR_BITS - 1);
    assign mdio_oe  = (ph == PH_PRE) || (ph == PH_TX);
    assign mdio_out = (ph == PH_PRE) ? 1'b1 : ((ph == PH_TX) ? txsr[FRAME_W-1] : 1'b0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            mdc       <= 1'b1;
            done      <= 1'b0;
            err       <= 1'b0;
            rdata     <= '0;
            txsr      <= '0;
            wr_q      <= 1'b0;
            tail_last <= 1'b0;
            div_q     <= DIV_W'(1);
        end else begin
            done <= 1'b0;
            if (accept) begin
                ph    <= PH_PRE;
                cnt   <= '0;
                mdc   <= 1'b0;
                err   <= 1'b0;
                wr_q  <= wr;
                div_q <= half_div;
                txsr  <= build_frame(wr, phy_addr, reg_addr, wdata);
            end else if (phase_end && !mdc) begin
                mdc <= 1'b1;
            end else if (slot_end) begin
                mdc <= 1'b0;
                case (ph)
                    PH_PRE: begin
                        if (cnt == CNT_W'(PRE_LEN - 1)) begin
                            ph  <= PH_TX;
                            cnt <= '0;
                        end else
                            cnt <= cnt + CNT_W'(1);
                    end
                    PH_TX: begin
                        txsr <= {txsr[FRAME_W-2:0], 1'b0};
                        if (cnt == tx_last) begin
                            cnt       <= '0;
                            tail_last <= 1'b0;
                            ph        <= wr_q ? PH_TAIL : PH_TA;
                        end else
                            cnt <= cnt + CNT_W'(1);
                    end
                    PH_TA: begin
                        cnt <= '0;
                        ph  <= mdio_in ? PH_FLUSH : PH_RX;
                    end
                    PH_RX: begin
                        if (cnt == CNT_W'(DATA_W - 1)) begin
                            ph        <= PH_TAIL;
                            cnt       <= '0;
                            tail_last <= 1'b1;
                        end else
                            cnt <= cnt + CNT_W'(1);
                    end
                    PH_TAIL: begin
                        if (cnt == CNT_W'(tail_last)) begin
                            ph   <= PH_IDLE;
                            mdc  <= 1'b1;
                            done <= 1'b1;
                            if (!wr_q)
                                rdata <= rx_word;
                        end else
                            cnt <= cnt + CNT_W'(1);
                    end
                    PH_FLUSH: begin
                        if (cnt == CNT_W'(FLUSH_LEN - 1)) begin
                            ph    <= PH_IDLE;
                            mdc   <= 1'b1;
                            done  <= 1'b1;
                            err   <= 1'b1;
                            rdata <= '0;
                        end else
                            cnt <= cnt + CNT_W'(1);
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    // R7: done lasts one cycle and never coincides with an active frame
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R6: the error flag only rises on completion
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIV_W-1:0]  half_div,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    logic              phase_end;
    logic              run;
    logic [DIV_W-1:0]  div_q;
    logic              rx_clr;
    logic              rx_shift;
    logic [DATA_W-1:0] rx_word;

    mdio_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .half_div  (div_q),
        .phase_end (phase_end)
    );

    mdio_rx_capture #(.W(DATA_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .clr    (rx_clr),
        .shift  (rx_shift),
        .bit_in (mdio_in),
        .word   (rx_word)
    );

    mdio_frame_seq #(.DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wr        (wr),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .wdata     (wdata),
        .half_div  (half_div),
        .mdio_in   (mdio_in),
        .phase_end (phase_end),
        .rx_word   (rx_word),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .run       (run),
        .div_q     (div_q),
        .rx_clr    (rx_clr),
        .rx_shift  (rx_shift)
    );

    // R3: line held steady across each high phase of the management clock
    a_r3_hold_while_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));
    // R8: idle bus state
    a_r8_idle_lines: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdc && !mdio_oe));
    // R8: a zero divider is never accepted
    a_r8_div_nonzero: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> (half_div != '0));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [7:0]  half_div = 8'd2;
    logic        busy, done, err, mdc, mdio_out, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int errors = 0;
    int nrise = 0;
    int nfall = 0;
    int busycnt, lowcnt;
    bit saw_done;
    bit phy_present = 1'b1;
    logic [15:0] phy_data = '0;
    logic r_oe [0:127];
    logic r_out[0:127];

    always #4 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst(rst), .start(start), .wr(wr), .phy_addr(phy_addr),
        .reg_addr(reg_addr), .wdata(wdata), .half_div(half_div), .busy(busy),
        .done(done), .err(err), .rdata(rdata), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // Record the line at every rising management-clock edge
    always @(posedge mdc) begin
        #1;
        if (nrise < 128) begin
            r_oe[nrise]  = mdio_oe;
            r_out[nrise] = mdio_out;
        end
        nrise++;
    end

    // PHY model: new value right after each falling edge
    always @(negedge mdc) begin
        int s;
        #1;
        s = nfall;
        nfall++;
        if (phy_present && s == 46)
            mdio_in = 1'b0;
        else if (phy_present && s >= 47 && s <= 62)
            mdio_in = phy_data[62 - s];
        else
            mdio_in = 1'b1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic w, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d,
                                     input int k);
        if (k < 32) return 1'b1;
        if (k == 32) return 1'b0;
        if (k == 33) return 1'b1;
        if (k == 34) return !w;
        if (k == 35) return w;
        if (k <= 40) return pa[40 - k];
        if (k <= 45) return ra[45 - k];
        if (k == 46) return 1'b1;
        if (k == 47) return 1'b0;
        return d[63 - k];
    endfunction

    task automatic run_frame(input logic w, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] d, input int div, input bit poke);
        @(negedge clk);
        nrise = 0; nfall = 0; busycnt = 0; lowcnt = 0; saw_done = 0;
        wr = w; phy_addr = pa; reg_addr = ra; wdata = d; half_div = 8'(div);
        start = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (poke && i == 20) begin
                start = 1'b1; wr = !w; phy_addr = ~pa; wdata = ~d;
            end else begin
                start = 1'b0; wr = w; phy_addr = pa; wdata = d;
            end
            if (done) begin saw_done = 1; break; end
            if (busy) busycnt++;
            if (!mdc) lowcnt++;
        end
        start = 1'b0;
    endtask

    task automatic check_header(input logic w, input logic [4:0] pa,
                                input logic [4:0] ra);
        int bad_pre = 0;
        int bad_hdr = 0;
        for (int k = 0; k < 32; k++)
            if (r_oe[k] !== 1'b1 || r_out[k] !== 1'b1) bad_pre++;
        for (int k = 32; k < 46; k++)
            if (r_oe[k] !== 1'b1 || r_out[k] !== exp_bit(w, pa, ra, 16'h0, k)) bad_hdr++;
        chk("R1", "preamble slot mismatches", bad_pre, 0);
        chk("R2", "header slot mismatches", bad_hdr, 0);
    endtask

    task automatic check_idle_after(input string req);
        chk(req, "done present", saw_done, 1);
        @(negedge clk);
        chk("R7", "done one cycle", done, 0);
        chk("R8", "idle mdc high", mdc, 1);
        chk("R8", "idle oe low", mdio_oe, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9", "reset busy", busy, 0);
        chk("R9", "reset done", done, 0);
        chk("R9", "reset err", err, 0);
        chk("R9", "reset rdata", rdata, 0);
        chk("R8", "reset mdc", mdc, 1);
        chk("R8", "reset oe", mdio_oe, 0);
    endtask

    task automatic t_write(input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] d, input int div, input bit poke);
        int bad = 0;
        int n_after;
        run_frame(1'b1, pa, ra, d, div, poke);
        chk("R7", "err after write", err, 0);
        check_idle_after("R4");
        chk("R4", "write slot count", nrise, 65);
        check_header(1'b1, pa, ra);
        for (int k = 46; k < 64; k++)
            if (r_oe[k] !== 1'b1 || r_out[k] !== exp_bit(1'b1, pa, ra, d, k)) bad++;
        chk("R4", "turnaround+data mismatches", bad, 0);
        chk("R4", "final slot released", r_oe[64], 0);
        chk("R3", "busy cycles", busycnt, 65 * 2 * div);
        chk("R3", "mdc low cycles", lowcnt, 65 * div);
        if (poke) begin
            n_after = nrise;
            repeat (40) @(negedge clk);
            chk("R7", "start during frame ignored (busy)", busy, 0);
            chk("R7", "start during frame ignored (edges)", nrise, n_after);
        end
    endtask

    task automatic t_read(input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] pd, input int div);
        int bad = 0;
        phy_present = 1'b1;
        phy_data = pd;
        run_frame(1'b0, pa, ra, 16'h0, div, 1'b0);
        chk("R5", "read data", rdata, pd);
        chk("R5", "err after good read", err, 0);
        check_idle_after("R5");
        chk("R5", "read slot count", nrise, 65);
        check_header(1'b0, pa, ra);
        for (int k = 46; k < 65; k++)
            if (r_oe[k] !== 1'b0) bad++;
        chk("R5", "released slots driven", bad, 0);
        chk("R3", "read busy cycles", busycnt, 65 * 2 * div);
    endtask

    task automatic t_absent(input int div);
        int bad = 0;
        phy_present = 1'b0;
        run_frame(1'b0, 5'h1E, 5'h02, 16'h0, div, 1'b0);
        chk("R6", "err on missing turnaround", err, 1);
        chk("R6", "rdata zero on error", rdata, 0);
        check_idle_after("R6");
        chk("R6", "error slot count", nrise, 79);
        for (int k = 46; k < 79; k++)
            if (r_oe[k] !== 1'b0) bad++;
        chk("R6", "flush slots driven", bad, 0);
        repeat (10) @(negedge clk);
        chk("R7", "err held after done", err, 1);
        phy_present = 1'b1;
    endtask

    task automatic t_mid_reset;
        phy_present = 1'b1;
        @(negedge clk);
        wr = 1'b0; phy_addr = 5'h07; reg_addr = 5'h04; half_div = 8'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        chk("R9", "busy before reset", busy, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "mid reset busy", busy, 0);
        chk("R9", "mid reset mdc", mdc, 1);
        chk("R9", "mid reset oe", mdio_oe, 0);
        chk("R9", "mid reset err", err, 0);
        chk("R9", "mid reset rdata", rdata, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write(5'h11, 5'h0A, 16'hA53C, 2, 1'b1);
        t_read(5'h03, 5'h1F, 16'hC3A5, 3);
        t_absent(1);
        t_write(5'h00, 5'h15, 16'h0001, 1, 1'b0);
        chk("R7", "err cleared by next request", err, 0);
        t_read(5'h1F, 5'h00, 16'h8001, 1);
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule